// File: doc/BRIEF.md
# Receive Sample FIFO with Sticky Overrun

This block buffers conversion samples between a producer that pushes one sample per cycle and a bus master that pops them. It holds sixteen entries in arrival order and shows the oldest one on its read-data output whenever it holds anything. A pop that finds the queue empty has no effect.

A packed, read-only 32-bit status word reports the raw write and read locations, full and empty flags, a sticky overrun flag and a watermark flag. The watermark flag is high when the fill level is at or above a programmable level. When a sample arrives at a full queue, the sample is thrown away and the overrun flag is set. The flag raises the interrupt output and stays high until software clears it. A push and a pop in the same cycle on a full queue count as a normal exchange and do not overrun.

Top module: `rxq_fifo`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `status_o` reads 0x00000004, with only the empty flag set, and `irq_o` is 0.
- R2: Bits 31 to 12 of `status_o` always read as zero.
- R3: Bits 11:8 of `status_o` hold the write location and bits 7:4 hold the read location. Each advances by one, modulo 16, for every accepted push or pop respectively.
- R4: Bit 3 of `status_o` is 1 exactly when 16 entries are stored. Bit 2 is 1 exactly when no entry is stored.
- R5: While the queue is not empty, `pop_data_o` shows the oldest stored sample. Samples leave in the order they were accepted.
- R6: A push without a pop while the queue is full is dropped. The stored samples and the write location stay unchanged. This holds for every such push until a pop frees an entry, after which a push is accepted again.
- R7: `irq_o` is 1 exactly while the overrun flag (bit 1) is 1.
- R8: The overrun flag sets on a dropped push. It stays set until a cycle with `ovr_clr_i` high and no new drop. When a clear and a drop fall in the same cycle, the flag stays set.
- R9: A push together with a pop on a full queue is accepted. The queue stays full and the overrun flag does not set.
- R10: A pop on an empty queue is ignored. Both locations and the empty flag stay unchanged.
- R11: Bit 0 is 1 when the stored count is greater than or equal to `wmark_i`. The flag is registered: it reflects the count after each edge, compared with the level present at that edge.
- R12: A push and a pop in the same cycle on a queue that is neither full nor empty leave the count unchanged and advance both locations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push one sample |
| push_data_i | input | DW (16) | Sample to push |
| pop_i | input | 1 | Remove the oldest sample |
| wmark_i | input | CW (5) | Watermark level, 0 to 16 |
| ovr_clr_i | input | 1 | Clear the sticky overrun flag |
| pop_data_o | output | DW (16) | Oldest stored sample |
| status_o | output | 32 | Packed status word |
| irq_o | output | 1 | Interrupt request from the overrun flag |

## Verification
Two events can fall in the same cycle: a software clear of the overrun flag and a fresh drop caused by a push into a full queue. The bench fills the queue, forces a first overrun, and then drives the clear together with another push while no pop is present. It judges the result by requiring the flag and the interrupt to stay high after that edge and to fall only after a later clear that comes alone. A second collision, a push together with a pop on a full queue, is judged by requiring no overrun and an unchanged full flag.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int STATUS_W    = 32;
    localparam int LOC_FIELD_W = 4;
    localparam int RSVD_W      = STATUS_W - 2 * LOC_FIELD_W - 4;

    typedef struct packed {
        logic [RSVD_W-1:0]      rsvd;
        logic [LOC_FIELD_W-1:0] wr_loc;
        logic [LOC_FIELD_W-1:0] rd_loc;
        logic                   full;
        logic                   empty;
        logic                   ovr;
        logic                   at_wm;
    } rxq_status_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } rxq_op_e;

endpackage

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nx,
    output logic          full,
    output logic          empty,
    output logic          wr_en,
    output logic          ovr_evt
);

    logic    do_pop;
    rxq_op_e op;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop & ~empty;
    assign wr_en   = push & (~full | do_pop);
    assign ovr_evt = push & full & ~do_pop;
    assign op      = rxq_op_e'({wr_en, do_pop});

    always_comb begin
        unique case (op)
            OP_PUSH: count_nx = count + 1'b1;
            OP_POP:  count_nx = count - 1'b1;
            default: count_nx = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en)  wr_ptr <= bump(wr_ptr);
            if (do_pop) rd_ptr <= bump(rd_ptr);
            count <= count_nx;
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ovr_evt,
    input  logic          ovr_clr,
    input  logic [CW-1:0] count_nx,
    input  logic [CW-1:0] wmark,
    output logic          ovr,
    output logic          at_wm
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr   <= 1'b0;
            at_wm <= 1'b0;
        end else begin
            if (ovr_evt)      ovr <= 1'b1;
            else if (ovr_clr) ovr <= 1'b0;
            at_wm <= (count_nx >= wmark);
        end
    end

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    input  logic [CW-1:0] wmark_i,
    input  logic          ovr_clr_i,
    output logic [DW-1:0] pop_data_o,
    output logic [31:0]   status_o,
    output logic          irq_o
);

    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count, count_nx;
    logic          full, empty, wr_en, ovr_evt;
    logic          ovr, at_wm;
    rxq_status_t   st;

    rxq_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .push     (push_i),
        .pop      (pop_i),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .count_nx (count_nx),
        .full     (full),
        .empty    (empty),
        .wr_en    (wr_en),
        .ovr_evt  (ovr_evt)
    );

    rxq_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_ptr),
        .wr_data (push_data_i),
        .rd_addr (rd_ptr),
        .rd_data (pop_data_o)
    );

    rxq_flags #(.CW(CW)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .ovr_evt  (ovr_evt),
        .ovr_clr  (ovr_clr_i),
        .count_nx (count_nx),
        .wmark    (wmark_i),
        .ovr      (ovr),
        .at_wm    (at_wm)
    );

    always_comb begin
        st        = '0;
        st.wr_loc = LOC_FIELD_W'(wr_ptr);
        st.rd_loc = LOC_FIELD_W'(rd_ptr);
        st.full   = full;
        st.empty  = empty;
        st.ovr    = ovr;
        st.at_wm  = at_wm;
    end

    assign status_o = st;
    assign irq_o    = ovr;

endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk (
    input logic        clk,
    input logic        rst,
    input logic        push_i,
    input logic        pop_i,
    input logic        ovr_clr_i,
    input logic [31:0] status_o,
    input logic        irq_o
);

    // R4: full and empty never together
    a_r4_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
        !(status_o[3] && status_o[2]));

    // R6: a dropped push keeps the write location
    a_r6_drop_keeps_wr: assert property (@(posedge clk) disable iff (rst)
        (status_o[3] && push_i && !pop_i) |=> $stable(status_o[11:8]) && status_o[3]);

    // R8: a dropped push sets the overrun flag and the interrupt
    a_r8_ovr_sets: assert property (@(posedge clk) disable iff (rst)
        (status_o[3] && push_i && !pop_i) |=> (status_o[1] && irq_o));

    // R8: flag is sticky without a clear
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_o[1] && !ovr_clr_i) |=> status_o[1]);

    // R9: exchange on a full queue does not overrun
    a_r9_full_exchange: assert property (@(posedge clk) disable iff (rst)
        (status_o[3] && push_i && pop_i && !status_o[1]) |=> (status_o[3] && !status_o[1]));

    // R10: pop on empty is ignored
    a_r10_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (status_o[2] && pop_i && !push_i) |=> ($stable(status_o[7:4]) && status_o[2]));

endmodule

bind rxq_fifo rxq_fifo_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .ovr_clr_i (ovr_clr_i),
    .status_o  (status_o),
    .irq_o     (irq_o)
);

// File: tb/sim_rxq_fifo.sv
`timescale 1ns/100ps
module sim_rxq_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_i = 1'b0;
    logic [15:0] push_data_i = '0;
    logic        pop_i = 1'b0;
    logic [4:0]  wmark_i = 5'd8;
    logic        ovr_clr_i = 1'b0;
    logic [15:0] pop_data_o;
    logic [31:0] status_o;
    logic        irq_o;

    int total = 0;
    int bad   = 0;

    // reference model from the requirements
    logic [15:0] mdl [16];
    int          m_cnt = 0;
    logic [3:0]  m_wp  = '0;
    logic [3:0]  m_rp  = '0;
    logic        m_ovr = 1'b0;
    logic        m_wm  = 1'b0;

    always #2.5 clk = ~clk;

    rxq_fifo u0 (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .pop_i       (pop_i),
        .wmark_i     (wmark_i),
        .ovr_clr_i   (ovr_clr_i),
        .pop_data_o  (pop_data_o),
        .status_o    (status_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {20'h0, m_wp, m_rp, (m_cnt == 16), (m_cnt == 0), m_ovr, m_wm};
    endfunction

    task automatic step(input logic ps, input logic [15:0] d, input logic pp,
                        input logic cl, input string tag);
        logic do_pop, do_push, ev;
        @(negedge clk);
        push_i = ps; push_data_i = d; pop_i = pp; ovr_clr_i = cl;
        #0.5;
        if (pp && m_cnt > 0) chk("R5 data", {16'h0, pop_data_o}, {16'h0, mdl[m_rp]});
        do_pop  = pp && (m_cnt > 0);
        do_push = ps && (m_cnt < 16 || do_pop);
        ev      = ps && (m_cnt == 16) && !do_pop;
        @(posedge clk);
        if (do_push) begin mdl[m_wp] = d; m_wp = m_wp + 1'b1; m_cnt++; end
        if (do_pop)  begin m_rp = m_rp + 1'b1; m_cnt--; end
        if (ev) m_ovr = 1'b1; else if (cl) m_ovr = 1'b0;
        m_wm = (m_cnt >= int'(wmark_i));
        #1;
        chk(tag, status_o, exp_status());
        chk("R7 irq", {31'h0, irq_o}, {31'h0, m_ovr});
        push_i = 1'b0; pop_i = 1'b0; ovr_clr_i = 1'b0;
    endtask

    task automatic drain(input string tag);
        while (m_cnt > 0) step(1'b0, '0, 1'b1, 1'b0, tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", status_o, 32'h0000_0004);
        chk("R1 reset irq", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 after release", status_o, 32'h0000_0004);
        chk("R2 reserved", {12'h0, status_o[31:12]}, 32'h0);
    endtask

    task automatic t_fill_drain;
        wmark_i = 5'd8;
        for (int i = 0; i < 16; i++) step(1'b1, 16'hA000 + 16'(i), 1'b0, 1'b0, "R4 R11 fill");
        chk("R4 full bit", {31'h0, status_o[3]}, 32'h1);
        chk("R3 write loc wrapped", {28'h0, status_o[11:8]}, 32'h0);
        drain("R5 R3 drain");
        chk("R4 empty bit", {31'h0, status_o[2]}, 32'h1);
    endtask

    task automatic t_empty_pop;
        step(1'b0, '0, 1'b1, 1'b0, "R10 pop on empty");
        step(1'b0, '0, 1'b1, 1'b0, "R10 pop on empty again");
        step(1'b1, 16'h5A5A, 1'b0, 1'b0, "R10 push after");
        drain("R5 after empty pop");
    endtask

    task automatic t_overrun;
        for (int i = 0; i < 16; i++) step(1'b1, 16'hB000 + 16'(i), 1'b0, 1'b0, "R4 fill");
        for (int i = 0; i < 3; i++) step(1'b1, 16'hDEAD, 1'b0, 1'b0, "R6 dropped push");
        chk("R8 flag set", {31'h0, status_o[1]}, 32'h1);
        step(1'b0, '0, 1'b1, 1'b0, "R6 free one");
        step(1'b1, 16'hC0DE, 1'b0, 1'b0, "R6 accepted after free");
        drain("R5 R6 contents kept");
        chk("R8 still set", {31'h0, status_o[1]}, 32'h1);
        step(1'b0, '0, 1'b0, 1'b1, "R8 clear");
        chk("R7 irq low", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_collision;
        for (int i = 0; i < 16; i++) step(1'b1, 16'hC100 + 16'(i), 1'b0, 1'b0, "R4 fill");
        step(1'b1, 16'hBAD0, 1'b0, 1'b0, "R8 first drop");
        step(1'b1, 16'hBAD1, 1'b0, 1'b1, "R8 clear with drop");
        chk("R8 collision keeps flag", {31'h0, status_o[1]}, 32'h1);
        step(1'b0, '0, 1'b0, 1'b1, "R8 clear alone");
        chk("R8 cleared", {31'h0, status_o[1]}, 32'h0);
    endtask

    task automatic t_full_exchange;
        for (int i = 0; i < 4; i++) step(1'b1, 16'hE000 + 16'(i), 1'b1, 1'b0, "R9 exchange");
        chk("R9 no overrun", {31'h0, status_o[1]}, 32'h0);
        chk("R9 still full", {31'h0, status_o[3]}, 32'h1);
        drain("R5 after exchange");
    endtask

    task automatic t_mid_both;
        for (int i = 0; i < 5; i++) step(1'b1, 16'h1000 + 16'(i), 1'b0, 1'b0, "R3 prefill");
        for (int i = 0; i < 20; i++) step(1'b1, 16'h2000 + 16'(i), 1'b1, 1'b0, "R12 R3 both");
        drain("R5 after both");
    endtask

    task automatic t_watermark;
        wmark_i = 5'd3;
        step(1'b1, 16'h0301, 1'b0, 1'b0, "R11 below");
        step(1'b1, 16'h0302, 1'b0, 1'b0, "R11 below");
        chk("R11 two under three", {31'h0, status_o[0]}, 32'h0);
        step(1'b1, 16'h0303, 1'b0, 1'b0, "R11 at level");
        chk("R11 at three", {31'h0, status_o[0]}, 32'h1);
        step(1'b0, '0, 1'b1, 1'b0, "R11 drop below");
        drain("R11 drain");
        wmark_i = 5'd0;
        step(1'b0, '0, 1'b0, 1'b0, "R11 level zero on empty");
        chk("R11 zero level", {31'h0, status_o[0]}, 32'h1);
        wmark_i = 5'd16;
        step(1'b0, '0, 1'b0, 1'b0, "R11 level sixteen");
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_drain();
        t_empty_pop();
        t_overrun();
        t_collision();
        drain("R5 after collision");
        t_full_exchange_setup();
        t_mid_both();
        t_watermark();
        chk("R2 reserved end", {12'h0, status_o[31:12]}, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic t_full_exchange_setup;
        for (int i = 0; i < 16; i++) step(1'b1, 16'hD000 + 16'(i), 1'b0, 1'b0, "R4 fill");
        t_full_exchange();
    endtask

endmodule